// File: doc/BRIEF.md
# Three-Stream Tone and Band Interleaver

This block sits after a rate 1/3 encoder. The encoder delivers one coded bit per beat, cycling through its three output streams, so that the beats of a span arrive as stream 0, stream 1, stream 2 for bit 0, then the same three for bit 1, and so on. A span is 200 bits per stream, 600 beats in all, and covers three OFDM symbols. The block splits the beats by stream and stores each stream's 200 bits in natural order. Once a whole span is stored, it plays each stream out on its own output channel in a strided order. The strided order walks the stored group in steps of ten, so bits that were neighbours at the encoder land far apart across the tones.

Each output channel is bound to one frequency band and carries that band's 2-bit identifier with every beat. Storage has two banks that take turns. One bank fills from the encoder while the other drains to the three outputs. The input and each output use a valid/ready handshake, and each output drains at its own pace.

Top module: `tone_band_interleaver`

## Requirements
- R1: While reset is held and just after its release, `in_ready` is 1 and `out_valid` is 3'b000.
- R2: Input beat j of a span (j = 0..599) is bit number j div 3 of stream j mod 3.
- R3: On output channel k, output position p (p = 0..199) carries stored bit index 10*(p mod 20) + (p div 20) of stream k.
- R4: `out_band` bits [2k+1:2k] of channel k always read k+1: 2'b01 for channel 0, 2'b10 for channel 1 and 2'b11 for channel 2.
- R5: `out_sos[k]` is 1 on output position 0 of each span and 0 on every other position.
- R6: No output channel raises `out_valid` for a span until all 600 beats of that span have been accepted.
- R7: A second span can be accepted while the first is still unread. When two complete spans are stored and unread, `in_ready` is 0 and no beat is accepted.
- R8: While `out_valid[k]` is 1 and `out_ready[k]` is 0, channel k holds `out_valid`, `out_bit` and `out_sos` unchanged into the next cycle.
- R9: The channels drain independently. A bank is freed only after all three channels have read their 200 bits from it. A channel that has finished drops `out_valid` until the next span is readable.
- R10: Spans leave each channel in the order they were accepted, with no loss or repetition across back-to-back spans.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Encoder beat present |
| in_ready | output | 1 | Block can take a beat |
| in_bit | input | 1 | Coded bit, streams interleaved by beat |
| out_valid | output | 3 | Per-channel output beat present |
| out_ready | input | 3 | Per-channel sink can take a beat |
| out_bit | output | 3 | Per-channel interleaved bit |
| out_band | output | 6 | Band identifier per channel, 2 bits each |
| out_sos | output | 3 | Per-channel start-of-span flag |

## Verification
A fault in the write position or stream selector shows up first at the output stage. The whole span emerges with bits in the wrong channel or the wrong order, and the first bad bit appears within 200 output beats of the span becoming readable. A fault in the bank-full or bank-pointer logic shows at the handshakes instead. It can stall `in_ready` too early or too late, let `out_valid` rise before a span is complete, or replay an old span, and it shows in the first span after the two banks have taken turns. The bench runs stalled-output phases and uneven per-channel back-pressure so that both kinds of fault are driven into view.

// File: rtl/tbi_pkg.sv
package tbi_pkg;
  localparam int NSTR = 3;

  // Band identifier bound to output channel k (channels 0..2 -> bands 1..3).
  function automatic logic [1:0] band_id(input int k);
    return 2'(k + 1);
  endfunction
endpackage

// File: rtl/tbi_wr_ctrl.sv
module tbi_wr_ctrl #(
  parameter int GROUP_LEN = 200,
  parameter int NSTR      = 3,
  localparam int AW = $clog2(GROUP_LEN),
  localparam int SW = $clog2(NSTR)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  output logic [AW-1:0] wr_pos,
  output logic [SW-1:0] wr_sel,
  output logic          span_done
);
  logic [AW-1:0] pos_q, pos_d;
  logic [SW-1:0] sel_q, sel_d;
  logic          last_sel, last_pos;

  assign last_sel  = (sel_q == SW'(NSTR - 1));
  assign last_pos  = (pos_q == AW'(GROUP_LEN - 1));
  assign span_done = accept && last_sel && last_pos;

  always_comb begin
    pos_d = pos_q;
    sel_d = sel_q;
    if (accept) begin
      if (last_sel) begin
        sel_d = '0;
        pos_d = last_pos ? '0 : pos_q + AW'(1);
      end else begin
        sel_d = sel_q + SW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= '0;
      sel_q <= '0;
    end else if (accept) begin
      pos_q <= pos_d;
      sel_q <= sel_d;
    end
  end

  assign wr_pos = pos_q;
  assign wr_sel = sel_q;

  // R2: the demux counters never leave their legal range.
  p_sel_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_q < SW'(NSTR)) && (pos_q < AW'(GROUP_LEN)));
endmodule

// File: rtl/tbi_store.sv
module tbi_store #(
  parameter int GROUP_LEN = 200,
  parameter int NSTR      = 3,
  localparam int AW = $clog2(GROUP_LEN),
  localparam int SW = $clog2(NSTR)
) (
  input  logic             clk,
  input  logic             we,
  input  logic             wbank,
  input  logic [SW-1:0]    wsel,
  input  logic [AW-1:0]    wpos,
  input  logic             wbit,
  input  logic             rbank,
  input  logic [NSTR*AW-1:0] raddr,
  output logic [NSTR-1:0]  rbit
);
  logic [GROUP_LEN-1:0] bank0 [NSTR];
  logic [GROUP_LEN-1:0] bank1 [NSTR];

  for (genvar k = 0; k < NSTR; k++) begin : g_lane
    logic wen0, wen1;
    logic [AW-1:0] ra;
    assign wen0 = we && !wbank && (wsel == SW'(k));
    assign wen1 = we &&  wbank && (wsel == SW'(k));
    assign ra   = raddr[k*AW +: AW];

    always_ff @(posedge clk) begin
      if (wen0) bank0[k][wpos] <= wbit;
    end

    always_ff @(posedge clk) begin
      if (wen1) bank1[k][wpos] <= wbit;
    end

    assign rbit[k] = rbank ? bank1[k][ra] : bank0[k][ra];
  end
endmodule

// File: rtl/tbi_rd_seq.sv
module tbi_rd_seq #(
  parameter int GROUP_LEN = 200,
  parameter int STRIDE    = 10,
  localparam int COLS = GROUP_LEN / STRIDE,
  localparam int AW   = $clog2(GROUP_LEN),
  localparam int CW   = $clog2(COLS),
  localparam int RW   = $clog2(STRIDE)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          avail,
  input  logic          ready,
  input  logic          release_bank,
  input  logic          rbit,
  output logic          valid,
  output logic          sos,
  output logic          dbit,
  output logic [AW-1:0] addr,
  output logic          done_or_last
);
  logic [CW-1:0] col_q, col_d;
  logic [RW-1:0] row_q, row_d;
  logic          done_q, done_d;
  logic          hs, last;

  assign valid = avail && !done_q;
  assign hs    = valid && ready;
  assign last  = (col_q == CW'(COLS - 1)) && (row_q == RW'(STRIDE - 1));
  assign addr  = AW'(col_q) * AW'(STRIDE) + AW'(row_q);
  assign sos   = (col_q == '0) && (row_q == '0);
  assign dbit  = rbit;
  assign done_or_last = done_q || (hs && last);

  always_comb begin
    col_d  = col_q;
    row_d  = row_q;
    done_d = done_q;
    if (hs) begin
      if (col_q == CW'(COLS - 1)) begin
        col_d = '0;
        row_d = last ? '0 : row_q + RW'(1);
        if (last) done_d = 1'b1;
      end else begin
        col_d = col_q + CW'(1);
      end
    end
    if (release_bank) done_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q  <= '0;
      row_q  <= '0;
      done_q <= 1'b0;
    end else begin
      col_q  <= col_d;
      row_q  <= row_d;
      done_q <= done_d;
    end
  end

  // R8: a stalled beat holds.
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ready) |=> (valid && $stable(sos) && $stable(dbit)));

  // R5: the beat after the start-of-span beat is never itself a start.
  p_sos_once_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (hs && sos) |=> !sos);
endmodule

// File: rtl/tone_band_interleaver.sv
module tone_band_interleaver #(
  parameter int GROUP_LEN = 200,
  parameter int STRIDE    = 10,
  localparam int NSTR = tbi_pkg::NSTR,
  localparam int AW   = $clog2(GROUP_LEN),
  localparam int SW   = $clog2(NSTR)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_bit,
  output logic [NSTR-1:0]   out_valid,
  input  logic [NSTR-1:0]   out_ready,
  output logic [NSTR-1:0]   out_bit,
  output logic [2*NSTR-1:0] out_band,
  output logic [NSTR-1:0]   out_sos
);
  logic [1:0] full_q, full_d;
  logic       wr_bank_q, rd_bank_q;
  logic       accept, span_done, release_bank;
  logic [AW-1:0] wr_pos;
  logic [SW-1:0] wr_sel;
  logic [NSTR*AW-1:0] raddr;
  logic [NSTR-1:0] rbit, fin;

  assign in_ready = !full_q[wr_bank_q];
  assign accept   = in_valid && in_ready;

  tbi_wr_ctrl #(.GROUP_LEN(GROUP_LEN), .NSTR(NSTR)) u_wr (
    .clk(clk), .rst_n(rst_n), .accept(accept),
    .wr_pos(wr_pos), .wr_sel(wr_sel), .span_done(span_done));

  tbi_store #(.GROUP_LEN(GROUP_LEN), .NSTR(NSTR)) u_mem (
    .clk(clk), .we(accept), .wbank(wr_bank_q), .wsel(wr_sel),
    .wpos(wr_pos), .wbit(in_bit), .rbank(rd_bank_q),
    .raddr(raddr), .rbit(rbit));

  assign release_bank = full_q[rd_bank_q] && (&fin);

  for (genvar k = 0; k < NSTR; k++) begin : g_chan
    tbi_rd_seq #(.GROUP_LEN(GROUP_LEN), .STRIDE(STRIDE)) u_rd (
      .clk(clk), .rst_n(rst_n), .avail(full_q[rd_bank_q]),
      .ready(out_ready[k]), .release_bank(release_bank),
      .rbit(rbit[k]), .valid(out_valid[k]), .sos(out_sos[k]),
      .dbit(out_bit[k]), .addr(raddr[k*AW +: AW]),
      .done_or_last(fin[k]));
    assign out_band[2*k +: 2] = tbi_pkg::band_id(k);

    // R5: a channel only comes alive on the first position of a span.
    p_first_sos_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out_valid[k]) |-> out_sos[k]);
  end

  always_comb begin
    full_d = full_q;
    if (span_done)    full_d[wr_bank_q] = 1'b1;
    if (release_bank) full_d[rd_bank_q] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q    <= '0;
      wr_bank_q <= 1'b0;
      rd_bank_q <= 1'b0;
    end else begin
      full_q <= full_d;
      if (span_done)    wr_bank_q <= !wr_bank_q;
      if (release_bank) rd_bank_q <= !rd_bank_q;
    end
  end

  // R7: input back-pressure only happens while some channel still has data to drain.
  p_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready) |-> (out_valid != '0));

  // R6: a completed span makes the read side busy in the next cycle.
  p_span_visible_r6: assert property (@(posedge clk) disable iff (!rst_n)
    span_done |=> (full_q != 2'b00));
endmodule

// File: tb/tb_tone_band_interleaver.sv
module tb_tone_band_interleaver;
  localparam int NSPAN = 6;
  localparam int SPAN  = 600;
  localparam int GL    = 200;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       in_valid, in_ready, in_bit;
  logic [2:0] out_valid, out_ready, out_bit, out_sos;
  logic [5:0] out_band;

  logic [SPAN-1:0] span_mem [NSPAN];
  logic [2:0] hold;
  int cnt [3];
  logic [2:0] stl, pbit, psos;
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  tone_band_interleaver dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_bit(in_bit), .out_valid(out_valid), .out_ready(out_ready),
    .out_bit(out_bit), .out_band(out_band), .out_sos(out_sos));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int src_beat(input int k, input int p);
    return 3 * (10 * (p % 20) + p / 20) + k;
  endfunction

  // Output monitor: pick readiness, then check the beats that will hand over.
  always @(negedge clk) begin
    if (rst_n) begin
      for (int k = 0; k < 3; k++) begin
        if (stl[k]) begin
          check(out_valid[k] == 1'b1, "R8 valid held", int'(out_valid[k]), 1);
          check(out_bit[k] == pbit[k] && out_sos[k] == psos[k], "R8 data held",
                int'(out_bit[k]), int'(pbit[k]));
        end
        out_ready[k] = !hold[k] && (($urandom % 4) != 0);
        stl[k] = out_valid[k] && !out_ready[k];
        pbit[k] = out_bit[k];
        psos[k] = out_sos[k];
        if (out_valid[k] && out_ready[k]) begin
          int s, p;
          s = cnt[k] / GL;
          p = cnt[k] % GL;
          if (s < NSPAN) begin
            check(out_bit[k] == span_mem[s][src_beat(k, p)], "R3 R2 R10 bit",
                  int'(out_bit[k]), int'(span_mem[s][src_beat(k, p)]));
          end else begin
            check(1'b0, "R10 extra beat", s, NSPAN - 1);
          end
          check(out_band[2*k +: 2] == 2'(k + 1), "R4 band", int'(out_band[2*k +: 2]), k + 1);
          check(out_sos[k] == (p == 0), "R5 sos", int'(out_sos[k]), int'(p == 0));
          cnt[k]++;
        end
      end
    end
  end

  task automatic send_span(input int s, input bit gaps);
    for (int j = 0; j < SPAN; j++) begin
      bit acc;
      if (gaps) begin
        while (($urandom % 5) == 0) begin
          in_valid = 1'b0;
          @(negedge clk);
        end
      end
      in_valid = 1'b1;
      in_bit   = span_mem[s][j];
      acc = 1'b0;
      while (!acc) begin
        acc = in_ready;
        @(posedge clk);
        @(negedge clk);
      end
      if (s == 0 && j == SPAN - 2)
        check(out_valid == 3'b000, "R6 not before full span", int'(out_valid), 0);
    end
    in_valid = 1'b0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20317));
    for (int s = 0; s < NSPAN; s++)
      for (int j = 0; j < SPAN; j++) span_mem[s][j] = 1'($urandom % 2);
    span_mem[0] = '0;
    span_mem[0][3*199 + 2] = 1'b1;   // single marker: last bit of stream 2
    span_mem[1] = {SPAN/2{2'b10}};
    for (int k = 0; k < 3; k++) cnt[k] = 0;
    stl = '0; pbit = '0; psos = '0;
    hold = 3'b111;
    in_valid = 1'b0; in_bit = 1'b0; out_ready = '0;
    rst_n = 1'b0;
    #1;
    check(in_ready == 1'b1 && out_valid == 3'b000, "R1 in reset", int'(in_ready), 1);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(in_ready == 1'b1, "R1 in_ready after reset", int'(in_ready), 1);
    check(out_valid == 3'b000, "R1 out_valid after reset", int'(out_valid), 0);

    send_span(0, 1'b0);
    @(negedge clk);
    check(out_valid == 3'b111, "R6 readable after span", int'(out_valid), 7);
    check(in_ready == 1'b1, "R7 second bank open", int'(in_ready), 1);
    send_span(1, 1'b0);
    @(negedge clk);
    check(in_ready == 1'b0, "R7 stall on two full banks", int'(in_ready), 0);
    in_valid = 1'b1; in_bit = span_mem[2][0];
    repeat (5) begin
      @(negedge clk);
      check(in_ready == 1'b0, "R7 no accept while stalled", int'(in_ready), 0);
    end
    in_valid = 1'b0;

    @(posedge clk);
    hold = 3'b100;
    wait (cnt[0] == GL && cnt[1] == GL);
    repeat (2) @(negedge clk);
    check(out_valid == 3'b100, "R9 finished channels idle", int'(out_valid), 4);
    check(in_ready == 1'b0, "R9 bank kept until all read", int'(in_ready), 0);
    @(posedge clk);
    hold = 3'b000;
    wait (cnt[2] == GL);
    repeat (2) @(negedge clk);
    check(in_ready == 1'b1, "R9 bank freed after last channel", int'(in_ready), 1);

    for (int s = 2; s < NSPAN; s++) send_span(s, 1'b1);
    wait (cnt[0] == NSPAN * GL && cnt[1] == NSPAN * GL && cnt[2] == NSPAN * GL);
    repeat (20) @(negedge clk);
    check(out_valid == 3'b000, "R10 all spans drained", int'(out_valid), 0);
    check(in_ready == 1'b1, "R10 input open at end", int'(in_ready), 1);
    for (int k = 0; k < 3; k++)
      check(cnt[k] == NSPAN * GL, "R10 beat count", cnt[k], NSPAN * GL);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule